// File: doc/BRIEF.md
# Limit-Based Interval Timer Array

This block holds a set of interval timers for a small multiprocessor: one private timer for each processor and one shared master timer. Each timer has a 21-bit counter that advances on a prescaled tick enable. When the counter has reached a programmed limit, the next tick restarts it at 1 and sets a sticky limit-reached flag. That flag is the timer's interrupt. Because the restart value is 1 and not 0, a limit of L gives an interrupt every L ticks.

A private timer drives the level-14 interrupt line of its own processor only. The master timer drives the level-10 line of every processor at once. Software reaches the timers over a simple 32-bit word bus. Each timer owns four consecutive words: limit, current count, limit-without-restart and control. Count and limit values sit in bits 30:10 of a word, and bit 31 carries the flag. Reading the limit word consumes the flag, which is how an interrupt is acknowledged.

Top module: `ivt_array`

## Requirements
- R1: After reset, every private timer's limit word reads 0x009C4000 and the master's limit word reads 0. Every count word reads 0x00000400 (count 1), and all interrupt outputs are low.
- R2: Each cycle with the tick enable high adds one to the counter in bits 30:10. A cycle with the tick low leaves the counter unchanged. Bits 9:0 of every count and limit word read as zero.
- R3: On a tick where the counter equals a nonzero limit, the counter becomes 1 and the timer's flag is set. The counter therefore never exceeds the limit.
- R4: The flag reads in bit 31 of both the limit word (offset 0) and the count word (offset 1).
- R5: Reading the limit word (offset 0) returns the flag and then clears it, which drops the interrupt. Reading the limit-without-restart word (offset 2) returns the same value and leaves the flag set. A flag being set in the same cycle as the read wins over the clear.
- R6: Writing the limit word (offset 0) loads the limit from bits 30:10 of the write data and restarts the counter at 1. All other write data bits are ignored.
- R7: Writing offset 2 loads the limit from bits 30:10 and leaves the running counter untouched.
- R8: A limit of zero lets the counter run through its full 21-bit range and wrap to 0. The flag is never raised.
- R9: The flag of private timer k drives only irq14 bit k. The flag of the master timer drives every bit of irq10.
- R10: Writing the control word (offset 3) stores all 32 bits, which read back unchanged and do not affect the counter, the limit or the flag.
- R11: Timer t occupies word addresses 4t to 4t+3, and the master is timer index NCPU. Read data appears on the cycle after the read strobe. An address whose timer index is above NCPU reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Prescaled count enable shared by all timers |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | $clog2(NCPU+1)+2 | Word address: timer index above, register offset in bits 1:0 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| irq14_o | output | NCPU | Level-14 interrupt for each processor, from that processor's private timer |
| irq10_o | output | NCPU | Level-10 interrupt for each processor, from the master timer |

## Verification
The bench targets the wrap point. It checks that a limit of 5 gives the count values 1 to 5 followed by 1 and the flag, so a design that wraps to 0 or raises the flag one tick late reads the wrong count. It separates the two limit writes. A design that restarts the counter on the offset-2 write shows count 1 where the bench expects the preserved count, and so fails. It checks that only a read at offset 0 clears the flag, so a design that clears on any read loses the interrupt after an offset-2 read. It also checks interrupt routing and the limit-zero free-run: a design that compares against zero would set a flag and raise irq10 where it must stay low.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DW      = 32;
  localparam int VAL_LSB = 10;
  localparam int CW      = 21;
  localparam int VAL_MSB = VAL_LSB + CW - 1;
  localparam int FLAG_B  = 31;

  typedef enum logic [1:0] {
    OFF_LIM = 2'd0,
    OFF_CNT = 2'd1,
    OFF_NCL = 2'd2,
    OFF_CTL = 2'd3
  } off_e;

  localparam logic [CW-1:0] PCPU_LIM_RST = 21'h002710;
  localparam logic [CW-1:0] MSTR_LIM_RST = 21'h000000;
endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter logic [CW-1:0] LIM_RST = PCPU_LIM_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rval_o,
  output logic          flag_o
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] lim_q, lim_nxt;
  logic [DW-1:0] ctl_q, ctl_nxt;
  logic          flag_q, flag_nxt;
  logic          wr_lim, wr_ncl, wr_ctl, rd_lim, at_lim, hit;

  assign wr_lim = wr_i && (off_i == OFF_LIM);
  assign wr_ncl = wr_i && (off_i == OFF_NCL);
  assign wr_ctl = wr_i && (off_i == OFF_CTL);
  assign rd_lim = rd_i && (off_i == OFF_LIM);
  assign at_lim = (lim_q != '0) && (cnt_q == lim_q);
  assign hit    = tick_i && !wr_lim && at_lim;

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_lim)      cnt_nxt = CW'(1);
    else if (tick_i) cnt_nxt = at_lim ? CW'(1) : cnt_q + CW'(1);
  end

  always_comb begin
    lim_nxt = lim_q;
    if (wr_lim || wr_ncl) lim_nxt = wdata_i[VAL_MSB:VAL_LSB];
  end

  always_comb begin
    ctl_nxt = ctl_q;
    if (wr_ctl) ctl_nxt = wdata_i;
  end

  always_comb begin
    flag_nxt = flag_q;
    if (hit)         flag_nxt = 1'b1;
    else if (rd_lim) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(1);
      lim_q  <= LIM_RST;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      lim_q  <= lim_nxt;
      ctl_q  <= ctl_nxt;
      flag_q <= flag_nxt;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_CNT: rval_o = {flag_q, cnt_q, {VAL_LSB{1'b0}}};
      OFF_CTL: rval_o = ctl_q;
      default: rval_o = {flag_q, lim_q, {VAL_LSB{1'b0}}};
    endcase
  end

  assign flag_o = flag_q;

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i && !at_lim) |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));
  // R3
  wrap_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i && at_lim) |=> (cnt_q == CW'(1) && flag_q));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && off_i == OFF_LIM && !(tick_i && at_lim)) |=> !flag_q);
  // R7
  noclear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && off_i == OFF_NCL && !tick_i) |=> $stable(cnt_q));
  // R8
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && !flag_q && !wr_i) |=> !flag_q);
endmodule

// File: rtl/ivt_array.sv
module ivt_array
  import ivt_pkg::*;
#(
  parameter int NCPU = 4,
  localparam int NT  = NCPU + 1,
  localparam int IW  = $clog2(NT),
  localparam int AW  = IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic [NCPU-1:0] irq14_o,
  output logic [NCPU-1:0] irq10_o
);
  logic          rst_sync_n;
  logic [IW-1:0] idx;
  logic [1:0]    off;
  logic [DW-1:0] tval [NT];
  logic [NT-1:0] tflag;
  logic [DW-1:0] rdata_q, rdata_nxt;
  logic          rd_any;

  ivt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign idx    = bus_addr_i[AW-1:2];
  assign off    = bus_addr_i[1:0];
  assign rd_any = bus_sel_i && !bus_wr_i;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic sel_g;
    assign sel_g = bus_sel_i && (idx == IW'(g));
    ivt_timer #(
      .LIM_RST ((g == NCPU) ? MSTR_LIM_RST : PCPU_LIM_RST)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick_i  (tick_i),
      .wr_i    (sel_g && bus_wr_i),
      .rd_i    (sel_g && !bus_wr_i),
      .off_i   (off),
      .wdata_i (bus_wdata_i),
      .rval_o  (tval[g]),
      .flag_o  (tflag[g])
    );
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_any) begin
      rdata_nxt = '0;
      for (int t = 0; t < NT; t++)
        if (idx == IW'(t)) rdata_nxt = tval[t];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_nxt;
  end

  assign bus_rdata_o = rdata_q;
  assign irq14_o     = tflag[NCPU-1:0];
  assign irq10_o     = {NCPU{tflag[NCPU]}};

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_any && idx > IW'(NCPU)) |=> (bus_rdata_o == '0));
endmodule

// File: tb/ivt_array_tb.sv
module ivt_array_tb;
  localparam int NCPU = 4;
  localparam int AW   = $clog2(NCPU + 1) + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic            sel = 1'b0;
  logic            wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCPU-1:0] irq14, irq10;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        cap = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ivt_array #(.NCPU(NCPU)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq14_o     (irq14),
    .irq10_o     (irq10)
  );

  function automatic logic [31:0] word(input bit flag, input int v);
    return {flag, 21'(v), 10'b0};
  endfunction

  function automatic logic [AW-1:0] ad(input int t, input int o);
    return AW'(t * 4 + o);
  endfunction

  always @(posedge clk) cap <= sel && !wr;

  always @(negedge clk) begin
    if (cap) begin
      logic [31:0] e;
      string tg;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected read act=%h exp=none", "R11", rdata);
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", tg, rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tg);
    exp_q.push_back(e); tag_q.push_back(tg);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) begin @(posedge clk); @(negedge clk); end
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] a, input logic [NCPU-1:0] e, input string tg);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s irq act=%b exp=%b", tg, a, e);
    end
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(irq14, '0, "R1");
    chk_irq(irq10, '0, "R1");
    bus_rd(ad(0, 0), 32'h009C4000, "R1");
    bus_rd(ad(3, 0), 32'h009C4000, "R1");
    bus_rd(ad(NCPU, 0), 32'h0, "R1");
    bus_rd(ad(2, 1), 32'h00000400, "R1");

    // R6 limit write with junk low bits, counter restarts at 1
    bus_wr(ad(0, 0), 32'h000017FF);
    bus_rd(ad(0, 0), word(0, 5), "R6");
    bus_rd(ad(0, 1), word(0, 1), "R6");
    // R2 count steps
    ticks(4);
    bus_rd(ad(0, 1), word(0, 5), "R2");
    // R3 wrap to 1 with flag, R4 flag in bit 31
    ticks(1);
    bus_rd(ad(0, 1), word(1, 1), "R3");
    // R9 routing of private timer
    chk_irq(irq14, 4'b0001, "R9");
    chk_irq(irq10, 4'b0000, "R9");
    // R5 read of limit word clears flag
    bus_rd(ad(0, 0), word(1, 5), "R4");
    chk_irq(irq14, 4'b0000, "R5");
    bus_rd(ad(0, 0), word(0, 5), "R5");

    // R7 limit write without restart
    bus_wr(ad(1, 0), word(0, 100));
    ticks(3);
    bus_wr(ad(1, 2), word(0, 7));
    bus_rd(ad(1, 1), word(0, 4), "R7");
    ticks(3);
    bus_rd(ad(1, 1), word(0, 7), "R7");
    ticks(1);
    chk_irq(irq14 & 4'b1110, 4'b0010, "R9");
    bus_rd(ad(1, 2), word(1, 7), "R5");
    chk_irq(irq14 & 4'b1110, 4'b0010, "R5");
    bus_rd(ad(1, 0), word(1, 7), "R5");
    chk_irq(irq14 & 4'b1110, 4'b0000, "R5");

    // R9 master broadcast
    bus_wr(ad(NCPU, 0), word(0, 3));
    ticks(2);
    chk_irq(irq10, 4'b0000, "R3");
    ticks(1);
    chk_irq(irq10, 4'b1111, "R9");
    bus_rd(ad(NCPU, 0), word(1, 3), "R5");
    chk_irq(irq10, 4'b0000, "R5");

    // R8 zero limit free-runs
    bus_wr(ad(NCPU, 0), 32'h0);
    ticks(20);
    chk_irq(irq10, 4'b0000, "R8");
    bus_rd(ad(NCPU, 1), word(0, 21), "R8");

    // R10 control stored, no effect on counter
    bus_wr(ad(2, 0), word(0, 1000));
    bus_wr(ad(2, 3), 32'hDEADBEEF);
    bus_rd(ad(2, 3), 32'hDEADBEEF, "R10");
    bus_rd(ad(2, 1), word(0, 1), "R10");
    bus_rd(ad(2, 0), word(0, 1000), "R10");

    // R11 unmapped index reads zero
    bus_rd(ad(NCPU + 1, 0), 32'h0, "R11");
    bus_rd(ad(NCPU + 2, 3), 32'h0, "R11");

    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 missing reads act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule